// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Front End

This block models, on a system clock, the digital register side of a two-channel parallel-input converter. Each channel holds two registers in series. The first is a staging register that captures the shared data bus. The second is an output register that drives the converter code. A two-bit channel address picks channel A, channel B, both channels, or neither. A write strobe (active low) and a load strobe pick one of four actions: stage, promote, pass-through or hold.

All inputs are sampled on the rising clock edge. Each action takes effect on every edge at which its strobe combination is present. A staged value reaches the output only when it is promoted. The two registers can therefore be filled one channel at a time and then updated on both channels at once.

An active-low reset forces all four registers to a reset code. A select pin chooses that code: zero-scale or midscale. The reset takes hold internally at once. Its release passes through a short synchronizer before normal operation resumes.

Top module: `dac_pair_regfront`

## Requirements
- R1: While `rst_n` is low, every rising clock edge loads both registers of both channels with the reset code, whatever `wr_n`, `ldac`, `addr` and `data` are.
- R2: The reset code is 14'h0000 when `rst_mid` is 0 and 14'h2000 when `rst_mid` is 1. `rst_mid` is sampled at each clock edge during reset, and the last such edge decides the code.
- R3: After `rst_n` rises, the first two clock edges still apply the reset. The third edge is the first at which a strobe action takes effect.
- R4: Channel address `addr` selects as follows: 2'b00 = channel A, 2'b11 = channel B, 2'b10 = both channels, 2'b01 = no channel.
- R5: With `wr_n`=0 and `ldac`=0 (stage), each selected channel's staging register takes `data`, and its output does not change.
- R6: With `wr_n`=1 and `ldac`=1 (promote), each selected channel's output register takes the value held in its staging register.
- R7: With `wr_n`=0 and `ldac`=1 (pass-through), both registers of each selected channel take `data`, so `data` shows on the output after that edge.
- R8: With `wr_n`=1 and `ldac`=0 (hold), no register changes.
- R9: A channel that the address does not select keeps both of its registers unchanged, whatever the strobes are.
- R10: If `wr_n` and `ldac` are driven low together for one cycle and then high together, the data present during the low cycle reaches the selected outputs after the high cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Reset, active low; asserts at once, releases through a synchronizer |
| rst_mid | input | 1 | Reset code select: 0 gives zero-scale, 1 gives midscale |
| wr_n | input | 1 | Write strobe, active low |
| ldac | input | 1 | Load strobe for the output registers |
| addr | input | 2 | Channel address (see R4) |
| data | input | 14 | Shared data bus |
| dac_a | output | 14 | Output register of channel A |
| dac_b | output | 14 | Output register of channel B |

## Verification
The bench loads different values into the two staging registers and promotes them later. A design that let staging write straight through to the output would show a value too early. A design that promoted from the bus instead of the staging register would show the wrong value. The address code 2'b01 is driven with all four strobe combinations. A decoder that mapped it to a channel would corrupt an output. The both-channels code is checked so that one update must reach A and B together. The reset tests change `rst_mid` between two reset edges and hold pass-through strobes active during reset and its release. A design without release synchronization, or one that latched the code too early, would either take the write two edges early or show the wrong reset code.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_STAGE = 2'd1,
      ACT_PROMOTE = 2'd2,
      ACT_THRU = 2'd3
   } dpr_act_e;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_A = 0;
   localparam int unsigned CH_B = 1;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_act
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("dpr_rst_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rel_q <= 1'b0;
            else        rel_q <= 1'b1;
         end
         assign rst_act = ~rel_q;
      end else begin : g_chain
         logic [STAGES-1:0] rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rel_q <= '0;
            else        rel_q <= {rel_q[STAGES-2:0], 1'b1};
         end
         assign rst_act = ~rel_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dpr_decode.sv
module dpr_decode
   import dpr_pkg::*;
(
   input  logic              wr_n,
   input  logic              ldac,
   input  logic [1:0]        addr,
   output dpr_act_e          act,
   output logic [NUM_CH-1:0] sel
);
   always_comb begin
      unique case ({wr_n, ldac})
         2'b00:   act = ACT_STAGE;
         2'b11:   act = ACT_PROMOTE;
         2'b01:   act = ACT_THRU;
         default: act = ACT_HOLD;
      endcase
   end

   always_comb begin
      sel = '0;
      unique case (addr)
         2'b00: sel[CH_A] = 1'b1;
         2'b11: sel[CH_B] = 1'b1;
         2'b10: begin
            sel[CH_A] = 1'b1;
            sel[CH_B] = 1'b1;
         end
         default: sel = '0;
      endcase
   end
endmodule

// File: rtl/dpr_chan.sv
module dpr_chan
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_act,
   input  logic [DATA_W-1:0] rst_code,
   input  dpr_act_e          act,
   input  logic              sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] out_q
);
   logic [DATA_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst_act) begin
         stage_q <= rst_code;
         out_q   <= rst_code;
      end else if (sel) begin
         unique case (act)
            ACT_STAGE:   stage_q <= din;
            ACT_PROMOTE: out_q   <= stage_q;
            ACT_THRU: begin
               stage_q <= din;
               out_q   <= din;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dac_pair_regfront.sv
module dac_pair_regfront
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W   = 14,
   parameter int unsigned SYNC_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_mid,
   input  logic              wr_n,
   input  logic              ldac,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b
);
   localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("dac_pair_regfront: DATA_W must be at least 2");
      end
   endgenerate

   logic              rst_act;
   logic [DATA_W-1:0] rst_code;
   dpr_act_e          act;
   logic [NUM_CH-1:0] sel;
   logic [DATA_W-1:0] ch_q [NUM_CH];

   assign rst_code = rst_mid ? MID_CODE : '0;

   dpr_rst_sync #(.STAGES(SYNC_LEN)) rsync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_act (rst_act)
   );

   dpr_decode dec_i (
      .wr_n (wr_n),
      .ldac (ldac),
      .addr (addr),
      .act  (act),
      .sel  (sel)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dpr_chan #(.DATA_W(DATA_W)) chan_i (
            .clk      (clk),
            .rst_act  (rst_act),
            .rst_code (rst_code),
            .act      (act),
            .sel      (sel[c]),
            .din      (data),
            .out_q    (ch_q[c])
         );
      end
   endgenerate

   assign dac_a = ch_q[CH_A];
   assign dac_b = ch_q[CH_B];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
   parameter int unsigned DATA_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_act,
   input logic              rst_mid,
   input logic              wr_n,
   input logic              ldac,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] data,
   input logic [DATA_W-1:0] dac_a,
   input logic [DATA_W-1:0] dac_b
);
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   // R1, R2: reset edge forces the selected code onto both outputs
   a_r2_reset_code: assert property (@(posedge clk)
      !rst_n |=> (dac_a == ($past(rst_mid) ? MID : '0)) && (dac_b == ($past(rst_mid) ? MID : '0)));

   // R8
   a_r8_hold: assert property (@(posedge clk) disable iff (rst_act)
      (wr_n && !ldac) |=> ($stable(dac_a) && $stable(dac_b)));

   // R5
   a_r5_stage_no_out: assert property (@(posedge clk) disable iff (rst_act)
      (!wr_n && !ldac) |=> ($stable(dac_a) && $stable(dac_b)));

   // R4
   a_r4_none_selected: assert property (@(posedge clk) disable iff (rst_act)
      (addr == 2'b01) |=> ($stable(dac_a) && $stable(dac_b)));

   // R9
   a_r9_b_only_keeps_a: assert property (@(posedge clk) disable iff (rst_act)
      (addr == 2'b11) |=> $stable(dac_a));

   // R9
   a_r9_a_only_keeps_b: assert property (@(posedge clk) disable iff (rst_act)
      (addr == 2'b00) |=> $stable(dac_b));

   // R7
   a_r7_thru_a: assert property (@(posedge clk) disable iff (rst_act)
      (!wr_n && ldac && (addr == 2'b00 || addr == 2'b10)) |=> (dac_a == $past(data)));

   // R7
   a_r7_thru_b: assert property (@(posedge clk) disable iff (rst_act)
      (!wr_n && ldac && (addr == 2'b11 || addr == 2'b10)) |=> (dac_b == $past(data)));
endmodule

bind dac_pair_regfront dpr_checker #(.DATA_W(DATA_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .rst_act (rst_act),
   .rst_mid (rst_mid),
   .wr_n    (wr_n),
   .ldac    (ldac),
   .addr    (addr),
   .data    (data),
   .dac_a   (dac_a),
   .dac_b   (dac_b)
);

// File: tb/dac_pair_regfront_tb_top.sv
module dac_pair_regfront_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         rst_mid = 1'b0;
   logic         wr_n = 1'b1;
   logic         ldac = 1'b0;
   logic [1:0]   addr = 2'b01;
   logic [W-1:0] data = '0;
   logic [W-1:0] dac_a, dac_b;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_pair_regfront dut_i (
      .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .wr_n(wr_n), .ldac(ldac),
      .addr(addr), .data(data), .dac_a(dac_a), .dac_b(dac_b)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic w, logic l, logic [1:0] a, logic [W-1:0] d);
      wr_n = w; ldac = l; addr = a; data = d;
   endtask

   // puts both channels in a known state: reset with the given code, then hold
   task automatic go_reset(logic mid);
      rst_n = 1'b0; rst_mid = mid;
      drive(1'b1, 1'b0, 2'b01, '0);
      tick();
      rst_n = 1'b1;
      tick(); tick();
   endtask

   task automatic t_reset_codes();
      // R1, R2: pass-through strobes active during reset are ignored
      rst_n = 1'b0; rst_mid = 1'b1;
      drive(1'b0, 1'b1, 2'b10, 14'h3FFF);
      tick();
      rst_mid = 1'b0;
      tick();
      chk("R2 zero code last sampled", dac_a, 14'h0000);
      chk("R1 reset overrides strobes", dac_b, 14'h0000);
      rst_mid = 1'b1;
      tick();
      chk("R2 midscale code A", dac_a, 14'h2000);
      chk("R2 midscale code B", dac_b, 14'h2000);
      // R3: release, strobes still pass-through
      rst_n = 1'b1;
      tick();
      chk("R3 first edge after release", dac_a, 14'h2000);
      tick();
      chk("R3 second edge after release", dac_b, 14'h2000);
      tick();
      chk("R3 third edge acts A", dac_a, 14'h3FFF);
      chk("R3 third edge acts B", dac_b, 14'h3FFF);
      drive(1'b1, 1'b0, 2'b01, '0);
   endtask

   task automatic t_stage_promote();
      go_reset(1'b0);
      drive(1'b0, 1'b0, 2'b00, 14'h1234);
      tick();
      chk("R5 staging leaves output", dac_a, 14'h0000);
      drive(1'b1, 1'b0, 2'b00, 14'h0F0F);
      tick();
      chk("R8 hold keeps output", dac_a, 14'h0000);
      drive(1'b1, 1'b1, 2'b00, 14'h0F0F);
      tick();
      chk("R6 promote staged value", dac_a, 14'h1234);
      chk("R9 channel B untouched", dac_b, 14'h0000);
      drive(1'b1, 1'b0, 2'b01, '0);
   endtask

   task automatic t_address();
      go_reset(1'b1);
      drive(1'b0, 1'b0, 2'b10, 14'h0ABC);
      tick();
      drive(1'b1, 1'b1, 2'b10, 14'h0000);
      tick();
      chk("R4 both-channel code A", dac_a, 14'h0ABC);
      chk("R4 both-channel code B", dac_b, 14'h0ABC);
      // R4: no-channel code with every strobe combination
      for (int k = 0; k < 4; k++) begin
         drive(k[1], k[0], 2'b01, 14'h1111);
         tick();
      end
      drive(1'b1, 1'b1, 2'b10, 14'h0000);
      tick();
      chk("R4 none code left A", dac_a, 14'h0ABC);
      chk("R4 none code left B", dac_b, 14'h0ABC);
      drive(1'b0, 1'b1, 2'b11, 14'h2222);
      tick();
      chk("R4 channel B code", dac_b, 14'h2222);
      chk("R9 channel A untouched", dac_a, 14'h0ABC);
      drive(1'b1, 1'b0, 2'b01, '0);
   endtask

   task automatic t_thru_and_pulse();
      go_reset(1'b0);
      drive(1'b0, 1'b1, 2'b00, 14'h0555);
      tick();
      chk("R7 pass-through output", dac_a, 14'h0555);
      drive(1'b1, 1'b1, 2'b00, 14'h0000);
      tick();
      chk("R7 pass-through also staged", dac_a, 14'h0555);
      // R10: tied strobes, low cycle then high cycle
      drive(1'b0, 1'b0, 2'b11, 14'h3001);
      tick();
      chk("R10 low phase no output", dac_b, 14'h0000);
      drive(1'b1, 1'b1, 2'b11, 14'h0000);
      tick();
      chk("R10 high phase updates", dac_b, 14'h3001);
      chk("R10 other channel kept", dac_a, 14'h0555);
      drive(1'b1, 1'b0, 2'b01, '0);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      t_reset_codes();
      t_stage_promote();
      t_address();
      t_thru_and_pulse();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule